// File: doc/BRIEF.md
# DRAM Row/Column Address Multiplexer

This block sits between a memory controller and the address pins of a DRAM device. It takes a flat byte address and produces the row address and the column address on the same set of pins, one after the other. A DRAM that needs its address split into row and column can then be attached directly, with no external multiplexer. A 17-bit output bus stands for external address pins 1 through 17. The pins above 17 carry no defined value during a DRAM access, so the block does not drive them.

A configuration code sets the DRAM column width. The code is an extension bit plus a 3-bit mode field, and it selects 8, 9, 10, 11 or 12 column bits. A phase input chooses which address drives the pins: the row address or the column address. A region-select input tells the block whether the current access targets DRAM space. When it does not, the address passes straight through. In the row phase, the low thirteen pins carry the address shifted down by the column width plus one. Each of the upper four pins takes a high address bit only when that bit exists; otherwise the pin keeps its own address bit.

All inputs are sampled at a rising clock edge. The pins and the error flag show the result from that clock edge onward, so a change on an input appears on the outputs one clock later.

Top module: `dram_addr_mux`

## Requirements
- R1: While rst_ni is low, pins_o is all zeros and cfg_err_o is 0.
- R2: Column phase: when dram_sel_i=1 and row_phase_i=0, pins_o[i] equals addr_i[i+1] for i=0..16, in every column-width mode. The outputs appear one clock after the inputs are sampled.
- R3: Code ext=0, amx=000 selects 8 column bits. In the row phase, pins_o[12:0]=addr_i[21:9] and pins_o[16:13]=addr_i[25:22].
- R4: Code ext=0, amx=001 selects 9 column bits. In the row phase, pins_o[12:0]=addr_i[22:10], pins_o[15:13]=addr_i[25:23] and pins_o[16]=addr_i[17].
- R5: Code ext=0, amx=010 selects 10 column bits. In the row phase, pins_o[12:0]=addr_i[23:11], pins_o[14:13]=addr_i[25:24] and pins_o[16:15]=addr_i[17:16].
- R6: Code ext=0, amx=011 selects 11 column bits. In the row phase, pins_o[12:0]=addr_i[24:12], pins_o[13]=addr_i[25] and pins_o[16:14]=addr_i[17:15].
- R7: Code ext=0, amx=100 selects 12 column bits. In the row phase, pins_o[12:0]=addr_i[25:13] and pins_o[16:13]=addr_i[17:14].
- R8: Any code with ext=1, or with amx from 101 to 111, is reserved. One clock after such a code is sampled, cfg_err_o is 1 and pins_o holds the column mapping, even in the row phase. For a valid code, cfg_err_o is 0.
- R9: When dram_sel_i=0, pins_o[i] equals addr_i[i+1], whatever the phase and the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 26 | Byte address, bits 25..0 |
| cfg_ext_i | input | 1 | Extension bit of the column-width code |
| cfg_amx_i | input | 3 | Mode field of the column-width code |
| dram_sel_i | input | 1 | Access targets DRAM space |
| row_phase_i | input | 1 | 1 = row address, 0 = column address |
| pins_o | output | 17 | Address pins 1..17 (bit i is pin i+1) |
| cfg_err_o | output | 1 | Reserved code was sampled |

## Verification
The bench drives each of the five valid codes in both phases with alternating-bit, mixed and all-ones addresses:
- The column phase must give the same pins under every code.
- In the row phase, a wrong shift amount shows up as a different low-pin field.

A walking single one across address bits 1 to 25, run in the 8-bit and 12-bit modes, shows which single pin each address bit lands on. This separates the case where an upper pin is replaced by a high address bit from the case where it keeps its own bit.

Reserved codes and non-DRAM accesses are each driven in the row phase, where a wrong mapping would differ from the column mapping. A phase toggle confirms that the outputs change one clock after the inputs.

// File: rtl/dram_addr_mux_pkg.sv
package dram_addr_mux_pkg;
  localparam int unsigned ADDR_W = 26;   // byte address width
  localparam int unsigned PIN_N  = 17;   // multiplexed pins 1..17
  localparam int unsigned LOW_N  = 13;   // pins that always shift in row phase
  localparam int unsigned MODE_N = 5;    // valid column widths
  localparam int unsigned CW_MIN = 8;    // narrowest column width
  localparam int unsigned AMX_W  = 3;

  typedef struct packed {
    logic             ext;
    logic [AMX_W-1:0] amx;
  } amux_cfg_t;
endpackage

// File: rtl/amux_mode_decode.sv
module amux_mode_decode
  import dram_addr_mux_pkg::*;
#(
  parameter int unsigned N_MODES = MODE_N,
  localparam int unsigned IDX_W  = (N_MODES > 1) ? $clog2(N_MODES) : 1
) (
  input  amux_cfg_t        cfg_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             rsvd_o
);
  logic in_range;

  always_comb begin
    in_range = (32'(cfg_i.amx) < N_MODES);
    rsvd_o   = cfg_i.ext | ~in_range;
    idx_o    = rsvd_o ? '0 : IDX_W'(cfg_i.amx);
  end
endmodule

// File: rtl/amux_row_map.sv
module amux_row_map
  import dram_addr_mux_pkg::*;
#(
  parameter int unsigned A_W     = ADDR_W,
  parameter int unsigned P_N     = PIN_N,
  parameter int unsigned N_MODES = MODE_N,
  parameter int unsigned CW_LO   = CW_MIN,
  localparam int unsigned IDX_W  = (N_MODES > 1) ? $clog2(N_MODES) : 1
) (
  input  logic [A_W-1:0]   addr_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [P_N-1:0]   row_o
);
  logic [P_N-1:0] cand [N_MODES];

  // pin i+1 takes address bit cw+i+1 when it exists, else keeps bit i+1
  for (genvar m = 0; m < N_MODES; m++) begin : g_mode
    localparam int unsigned CW = CW_LO + m;
    for (genvar i = 0; i < P_N; i++) begin : g_pin
      if (CW + i + 1 < A_W) begin : g_shift
        assign cand[m][i] = addr_i[CW+i+1];
      end else begin : g_keep
        assign cand[m][i] = addr_i[i+1];
      end
    end
  end

  always_comb begin
    row_o = cand[0];
    for (int m = 1; m < N_MODES; m++)
      if (32'(idx_i) == m) row_o = cand[m];
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_addr_mux_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cfg_ext_i,
  input  logic [AMX_W-1:0]  cfg_amx_i,
  input  logic              dram_sel_i,
  input  logic              row_phase_i,
  output logic [PIN_N-1:0]  pins_o,
  output logic              cfg_err_o
);
  localparam int unsigned IDX_W = (MODE_N > 1) ? $clog2(MODE_N) : 1;

  amux_cfg_t        cfg;
  logic [IDX_W-1:0] mode_idx;
  logic             rsvd;
  logic [PIN_N-1:0] row_addr, col_addr, pins_d;

  assign cfg = '{ext: cfg_ext_i, amx: cfg_amx_i};

  amux_mode_decode #(.N_MODES(MODE_N)) u_dec (
    .cfg_i  (cfg),
    .idx_o  (mode_idx),
    .rsvd_o (rsvd)
  );

  amux_row_map #(
    .A_W(ADDR_W), .P_N(PIN_N), .N_MODES(MODE_N), .CW_LO(CW_MIN)
  ) u_row (
    .addr_i (addr_i),
    .idx_i  (mode_idx),
    .row_o  (row_addr)
  );

  assign col_addr = addr_i[PIN_N:1];

  always_comb begin
    pins_d = col_addr;
    if (dram_sel_i && row_phase_i && !rsvd) pins_d = row_addr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_o    <= '0;
      cfg_err_o <= 1'b0;
    end else begin
      pins_o    <= pins_d;
      cfg_err_o <= rsvd;
    end
  end
endmodule

// File: rtl/dram_addr_mux_chk.sv
module dram_addr_mux_chk
  import dram_addr_mux_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              cfg_ext_i,
  input logic [AMX_W-1:0]  cfg_amx_i,
  input logic              dram_sel_i,
  input logic              row_phase_i,
  input logic [PIN_N-1:0]  pins_o,
  input logic              cfg_err_o
);
  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;

  logic bad_code;
  assign bad_code = cfg_ext_i || (cfg_amx_i > 3'd4);

  always_comb begin
    if (!rst_ni) begin
      p_reset_r1: assert (pins_o == '0 && !cfg_err_o)
        else $error("R1 reset state");
    end
  end

  p_col_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(!row_phase_i) |-> pins_o == $past(addr_i[17:1]));

  p_row8_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(dram_sel_i && row_phase_i && !cfg_ext_i && cfg_amx_i == 3'd0)
    |-> pins_o == $past({addr_i[25:22], addr_i[21:9]}));

  p_row12_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(dram_sel_i && row_phase_i && !cfg_ext_i && cfg_amx_i == 3'd4)
    |-> pins_o == $past({addr_i[17:14], addr_i[25:13]}));

  p_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> cfg_err_o == $past(bad_code));

  p_rsvd_pins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(bad_code) |-> pins_o == $past(addr_i[17:1]));

  p_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(!dram_sel_i) |-> pins_o == $past(addr_i[17:1]));
endmodule

bind dram_addr_mux dram_addr_mux_chk u_chk (.*);

// File: tb/dram_addr_mux_tb.sv
module dram_addr_mux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] addr = '0;
  logic        ext = 1'b0;
  logic [2:0]  amx = '0;
  logic        sel = 1'b0;
  logic        row = 1'b0;
  logic [16:0] pins;
  logic        err;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  dram_addr_mux u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .cfg_ext_i(ext),
    .cfg_amx_i(amx), .dram_sel_i(sel), .row_phase_i(row),
    .pins_o(pins), .cfg_err_o(err)
  );

  function automatic logic [16:0] exp_pins(logic [25:0] a, logic e, logic [2:0] m,
                                           logic s, logic r);
    logic [16:0] col = a[17:1];
    if (!s || !r || e) return col;
    case (m)
      3'd0: return {a[25:22], a[21:9]};
      3'd1: return {a[17], a[25:23], a[22:10]};
      3'd2: return {a[17:16], a[25:24], a[23:11]};
      3'd3: return {a[17:15], a[25], a[24:12]};
      3'd4: return {a[17:14], a[25:13]};
      default: return col;
    endcase
  endfunction

  task automatic chk(string tag, logic [16:0] got, logic [16:0] want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: got %05h expected %05h", tag, got, want);
    end
  endtask

  // drive at negedge, sample at the next negedge (one register stage)
  task automatic apply(string tag, logic [25:0] a, logic e, logic [2:0] m,
                       logic s, logic r);
    addr = a; ext = e; amx = m; sel = s; row = r;
    @(negedge clk);
    chk(tag, pins, exp_pins(a, e, m, s, r));
    chk({tag, " err"}, {16'd0, err}, {16'd0, (e || m > 3'd4)});
  endtask

  function automatic string mode_tag(int m);
    case (m)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic t_reset();
    addr = 26'h3FFFFFF; sel = 1'b1; row = 1'b1;
    #1;
    chk("R1 pins", pins, '0);
    chk("R1 err", {16'd0, err}, '0);
    @(negedge clk);
    chk("R1 pins held", pins, '0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_column();
    logic [25:0] pats [3] = '{26'h2AAAAAA, 26'h1555554, 26'h3C0F0F2};
    for (int m = 0; m < 5; m++)
      foreach (pats[p]) apply("R2 column", pats[p], 1'b0, 3'(m), 1'b1, 1'b0);
  endtask

  task automatic t_rows();
    logic [25:0] pats [3] = '{26'h2AAAAAA, 26'h0123456, 26'h3FFFFFE};
    for (int m = 0; m < 5; m++)
      foreach (pats[p]) apply(mode_tag(m), pats[p], 1'b0, 3'(m), 1'b1, 1'b1);
  endtask

  task automatic t_walk();
    for (int b = 1; b < 26; b++) begin
      apply("R3 walk", 26'd1 << b, 1'b0, 3'd0, 1'b1, 1'b1);
      apply("R7 walk", 26'd1 << b, 1'b0, 3'd4, 1'b1, 1'b1);
      apply("R5 walk", 26'd1 << b, 1'b0, 3'd2, 1'b1, 1'b1);
    end
  endtask

  task automatic t_reserved();
    for (int m = 0; m < 8; m++)
      apply("R8 ext", 26'h2AAAAAA, 1'b1, 3'(m), 1'b1, 1'b1);
    for (int m = 5; m < 8; m++)
      apply("R8 amx", 26'h3C0F0F2, 1'b0, 3'(m), 1'b1, 1'b1);
    apply("R8 valid again", 26'h3C0F0F2, 1'b0, 3'd1, 1'b1, 1'b1);
  endtask

  task automatic t_passthru();
    for (int m = 0; m < 5; m++)
      apply("R9 non-dram", 26'h2AAAAAA, 1'b0, 3'(m), 1'b0, 1'b1);
  endtask

  task automatic t_latency();
    addr = 26'h0123456; ext = 1'b0; amx = 3'd0; sel = 1'b1; row = 1'b0;
    @(negedge clk);
    row = 1'b1;
    #1;
    chk("R2 no early change", pins, 17'(26'h0123456 >> 1));
    @(negedge clk);
    chk("R3 after one clock", pins, exp_pins(26'h0123456, 1'b0, 3'd0, 1'b1, 1'b1));
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_column();
    t_rows();
    t_walk();
    t_reserved();
    t_passthru();
    t_latency();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule